// File: doc/BRIEF.md
# Error Event Signaling Classifier

This block sits beside the error detectors of a PCI Express function. Each cycle it may receive one detected error event: a status vector that should carry exactly one bit and a flag that says whether the event is of the correctable or the uncorrectable kind. The block reads the function's current mask, severity, device-control enable and command-register SERR enable values from its inputs. From these it works out four things: which status bits to set, whether the header log must capture the event, whether an error message is emitted, and at which severity.

All results for one event appear together, as registered one-cycle strobes, on the clock edge after the event is presented. The surrounding register file ORs the set strobes into its status registers. The log machinery acts on the log request, and the upstream path forwards the message. Two special routes are handled. An uncorrectable non-fatal event that may be advisory is reported as a correctable event. An unsupported request has its own reporting enable, which gates its message.

Top module: `err_sig_classifier`

## Requirements
- R1: After the status is ANDed with the supported-bit set of its kind, a result that is zero or has more than one bit set rejects the event. Rejection pulses `evt_reject` and drives every status strobe, `log_req` and `msg_valid` low.
- R2: An accepted correctable event sets its own bit in `cor_status_set` and always sets `devsta_set[0]` (correctable detected).
- R3: A correctable event whose bit is 1 in `cor_mask` still sets its status bit but emits no message.
- R4: An unmasked correctable event emits a message only when `cor_rpt_en` is 1. Its severity code is 0.
- R5: An uncorrectable event is fatal when its bit in `unc_sev` is 1 and non-fatal otherwise. It sets `devsta_set[2]` (fatal) or `devsta_set[1]` (non-fatal) to match.
- R6: A non-advisory uncorrectable event whose bit is 1 in `unc_mask` sets its bit in `unc_status_set` but raises neither `log_req` nor `msg_valid`.
- R7: An unmasked, non-advisory uncorrectable event sets its bit in `unc_status_set` and raises `log_req`.
- R8: A fatal message (code 2) requires `serr_en` or `fatal_rpt_en`. A non-fatal message (code 1) requires `serr_en` or `nonfatal_rpt_en`.
- R9: An uncorrectable event on bit `UR_BIT` (20 by default) is an unsupported request and sets `devsta_set[3]`. While both `ur_rpt_en` and `serr_en` are 0, it emits no message.
- R10: A non-fatal uncorrectable event with `evt_maybe_adv` set is reported as a correctable event on bit `ADV_BIT` (13 by default). It sets `devsta_set[0]` and that bit of `cor_status_set`, and emits a code-0 message when `cor_rpt_en` is 1 and, for an unsupported request, `ur_rpt_en` is 1. When its uncorrectable bit is clear in `unc_mask`, it also sets that bit in `unc_status_set` and raises `log_req`.
- R11: If bit `ADV_BIT` of `cor_mask` is 1, an advisory event sets only `devsta_set` and `cor_status_set`. It requests no log, sets no uncorrectable status bit and emits no message.
- R12: All outputs are registered one-cycle pulses that appear on the clock edge after `evt_valid`. In a cycle after which no event was presented, every output is 0. Reset clears all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | An error event is presented this cycle |
| evt_status | input | ERR_W | Error status bit of the event, expected one-hot |
| evt_is_cor | input | 1 | 1 = correctable kind, 0 = uncorrectable kind |
| evt_maybe_adv | input | 1 | Uncorrectable event may be treated as advisory |
| cor_mask | input | ERR_W | Correctable mask register value |
| unc_mask | input | ERR_W | Uncorrectable mask register value |
| unc_sev | input | ERR_W | Uncorrectable severity register value (1 = fatal) |
| cor_rpt_en | input | 1 | Correctable reporting enable |
| nonfatal_rpt_en | input | 1 | Non-fatal reporting enable |
| fatal_rpt_en | input | 1 | Fatal reporting enable |
| ur_rpt_en | input | 1 | Unsupported-request reporting enable |
| serr_en | input | 1 | Command register SERR enable |
| cor_status_set | output | ERR_W | Set strobe for the correctable status register |
| unc_status_set | output | ERR_W | Set strobe for the uncorrectable status register |
| devsta_set | output | 4 | Device status set strobe: [0] cor, [1] non-fatal, [2] fatal, [3] UR |
| log_req | output | 1 | Request to log the event as an uncorrectable error |
| msg_valid | output | 1 | One-cycle error message pulse |
| msg_sev | output | 2 | Message severity: 0 correctable, 1 non-fatal, 2 fatal |
| evt_reject | output | 1 | Event rejected as malformed |

## Verification
The bench builds the block with its default parameters: 32-bit status vectors, a correctable supported set of 0x0000F1C1, an uncorrectable supported set of 0x03FFF030, unsupported request on bit 20 and advisory on bit 13. Because both supported sets leave gaps, a single bit can be legal for one kind and rejected for the other, so R1 can be reached through unsupported bits and not only through zero or multi-bit vectors. Bit 20 and bit 13 both lie inside these sets, so the unsupported-request and advisory routes can be combined in one event.

// File: rtl/err_sig_pkg.sv
// Shared types for the error signaling classifier.
// Assumes: severity codes are consumed by an upstream message path that
// understands 0 = correctable, 1 = non-fatal, 2 = fatal.
package err_sig_pkg;

    typedef enum logic [1:0] {
        SEV_COR      = 2'd0,
        SEV_NONFATAL = 2'd1,
        SEV_FATAL    = 2'd2
    } err_sev_e;

    // Bit positions inside the device status set strobe.
    localparam int DS_COR      = 0;
    localparam int DS_NONFATAL = 1;
    localparam int DS_FATAL    = 2;
    localparam int DS_UR       = 3;
    localparam int DS_W        = 4;

endpackage

// File: rtl/err_evt_qualify.sv
// Event qualifier: strips unsupported bits from the raw status and decides
// whether exactly one supported bit remains.
// Assumes: the supported sets are constant for the life of the chip.
module err_evt_qualify #(
    parameter int          ERR_W   = 32,
    parameter logic [31:0] COR_SUP = 32'h0000_F1C1,
    parameter logic [31:0] UNC_SUP = 32'h03FF_F030
) (
    input  logic [ERR_W-1:0] raw_status,
    input  logic             is_cor,
    output logic [ERR_W-1:0] clean_status,
    output logic             one_hot_ok
);
    localparam logic [ERR_W-1:0] COR_KEEP = COR_SUP[ERR_W-1:0];
    localparam logic [ERR_W-1:0] UNC_KEEP = UNC_SUP[ERR_W-1:0];

    logic [ERR_W-1:0] less_one;

    // Keep only the bits this kind of event may carry.
    always_comb begin
        clean_status = raw_status & (is_cor ? COR_KEEP : UNC_KEEP);
        less_one     = clean_status - {{(ERR_W-1){1'b0}}, 1'b1};
        one_hot_ok   = (clean_status != '0) && ((clean_status & less_one) == '0);
    end

endmodule

// File: rtl/err_sig_route.sv
// Routing decision: from a qualified one-hot event and the register values,
// works out status strobes, log request and message severity.
// Assumes: clean_status is one-hot whenever the result is used.
module err_sig_route
    import err_sig_pkg::*;
#(
    parameter int ERR_W   = 32,
    parameter int UR_BIT  = 20,
    parameter int ADV_BIT = 13
) (
    input  logic [ERR_W-1:0] clean_status,
    input  logic             is_cor,
    input  logic             maybe_adv,
    input  logic [ERR_W-1:0] cor_mask,
    input  logic [ERR_W-1:0] unc_mask,
    input  logic [ERR_W-1:0] unc_sev,
    input  logic             cor_rpt_en,
    input  logic             nonfatal_rpt_en,
    input  logic             fatal_rpt_en,
    input  logic             ur_rpt_en,
    input  logic             serr_en,
    output logic [ERR_W-1:0] cor_set,
    output logic [ERR_W-1:0] unc_set,
    output logic [DS_W-1:0]  devsta,
    output logic             log_req,
    output logic             msg,
    output err_sev_e         sev
);
    localparam logic [ERR_W-1:0] ADV_ONE = {{(ERR_W-1){1'b0}}, 1'b1} << ADV_BIT;

    logic             is_ur;
    logic             is_fatal;
    logic             is_adv;
    logic             cor_like;
    logic [ERR_W-1:0] cor_bit;
    logic             cor_masked;
    logic             unc_masked;

    // Classify the event into one of the reporting routes.
    always_comb begin
        is_ur      = !is_cor && clean_status[UR_BIT];
        is_fatal   = !is_cor && ((clean_status & unc_sev) != '0);
        is_adv     = !is_cor && !is_fatal && maybe_adv;
        cor_like   = is_cor || is_adv;
        cor_bit    = is_cor ? clean_status : ADV_ONE;
        cor_masked = (cor_bit & cor_mask) != '0;
        unc_masked = (clean_status & unc_mask) != '0;
    end

    // Produce strobes and message decision for the chosen route.
    always_comb begin
        cor_set = '0;
        unc_set = '0;
        devsta  = '0;
        log_req = 1'b0;
        msg     = 1'b0;
        sev     = SEV_COR;
        devsta[DS_UR] = is_ur;
        if (cor_like) begin
            devsta[DS_COR] = 1'b1;
            cor_set        = cor_bit;
            if (!cor_masked) begin
                if (is_adv && !unc_masked) begin
                    log_req = 1'b1;
                    unc_set = clean_status;
                end
                msg = cor_rpt_en && !(is_ur && !ur_rpt_en);
            end
        end else begin
            devsta[DS_FATAL]    = is_fatal;
            devsta[DS_NONFATAL] = !is_fatal;
            unc_set             = clean_status;
            sev                 = is_fatal ? SEV_FATAL : SEV_NONFATAL;
            if (!unc_masked) begin
                log_req = 1'b1;
                if (!(is_ur && !ur_rpt_en && !serr_en)) begin
                    msg = is_fatal ? (serr_en || fatal_rpt_en)
                                   : (serr_en || nonfatal_rpt_en);
                end
            end
        end
    end

endmodule

// File: rtl/err_sig_classifier.sv
// Top of the error signaling classifier. Qualifies the incoming event,
// routes it, and registers every result so all strobes of one event
// appear together on the edge after evt_valid.
// Assumes: at most one event per cycle; register inputs stable in that cycle.
module err_sig_classifier
    import err_sig_pkg::*;
#(
    parameter int          ERR_W   = 32,
    parameter logic [31:0] COR_SUP = 32'h0000_F1C1,
    parameter logic [31:0] UNC_SUP = 32'h03FF_F030,
    parameter int          UR_BIT  = 20,
    parameter int          ADV_BIT = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    input  logic [ERR_W-1:0] evt_status,
    input  logic             evt_is_cor,
    input  logic             evt_maybe_adv,
    input  logic [ERR_W-1:0] cor_mask,
    input  logic [ERR_W-1:0] unc_mask,
    input  logic [ERR_W-1:0] unc_sev,
    input  logic             cor_rpt_en,
    input  logic             nonfatal_rpt_en,
    input  logic             fatal_rpt_en,
    input  logic             ur_rpt_en,
    input  logic             serr_en,
    output logic [ERR_W-1:0] cor_status_set,
    output logic [ERR_W-1:0] unc_status_set,
    output logic [3:0]       devsta_set,
    output logic             log_req,
    output logic             msg_valid,
    output logic [1:0]       msg_sev,
    output logic             evt_reject
);
    logic [ERR_W-1:0] clean_status;
    logic             one_hot_ok;
    logic [ERR_W-1:0] nx_cor;
    logic [ERR_W-1:0] nx_unc;
    logic [DS_W-1:0]  nx_dev;
    logic             nx_log;
    logic             nx_msg;
    err_sev_e         nx_sev;
    logic             take;

    err_evt_qualify #(
        .ERR_W   (ERR_W),
        .COR_SUP (COR_SUP),
        .UNC_SUP (UNC_SUP)
    ) u_qualify (
        .raw_status   (evt_status),
        .is_cor       (evt_is_cor),
        .clean_status (clean_status),
        .one_hot_ok   (one_hot_ok)
    );

    err_sig_route #(
        .ERR_W   (ERR_W),
        .UR_BIT  (UR_BIT),
        .ADV_BIT (ADV_BIT)
    ) u_route (
        .clean_status    (clean_status),
        .is_cor          (evt_is_cor),
        .maybe_adv       (evt_maybe_adv),
        .cor_mask        (cor_mask),
        .unc_mask        (unc_mask),
        .unc_sev         (unc_sev),
        .cor_rpt_en      (cor_rpt_en),
        .nonfatal_rpt_en (nonfatal_rpt_en),
        .fatal_rpt_en    (fatal_rpt_en),
        .ur_rpt_en       (ur_rpt_en),
        .serr_en         (serr_en),
        .cor_set         (nx_cor),
        .unc_set         (nx_unc),
        .devsta          (nx_dev),
        .log_req         (nx_log),
        .msg             (nx_msg),
        .sev             (nx_sev)
    );

    // An accepted event is one that is presented and well formed.
    assign take = evt_valid && one_hot_ok;

    // Register all results of the event as single-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cor_status_set <= '0;
            unc_status_set <= '0;
            devsta_set     <= '0;
            log_req        <= 1'b0;
            msg_valid      <= 1'b0;
            msg_sev        <= SEV_COR;
            evt_reject     <= 1'b0;
        end else begin
            cor_status_set <= take ? nx_cor : '0;
            unc_status_set <= take ? nx_unc : '0;
            devsta_set     <= take ? nx_dev : '0;
            log_req        <= take && nx_log;
            msg_valid      <= take && nx_msg;
            msg_sev        <= (take && nx_msg) ? nx_sev : SEV_COR;
            evt_reject     <= evt_valid && !one_hot_ok;
        end
    end

endmodule

// File: rtl/err_sig_classifier_chk.sv
// Checker for the error signaling classifier, bound to every instance.
// Assumes: the default device status bit layout of err_sig_pkg.
module err_sig_classifier_chk #(
    parameter int ERR_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evt_valid,
    input logic [ERR_W-1:0] cor_status_set,
    input logic [ERR_W-1:0] unc_status_set,
    input logic [3:0]       devsta_set,
    input logic             log_req,
    input logic             msg_valid,
    input logic [1:0]       msg_sev,
    input logic             evt_reject
);
    assert_reject_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        evt_reject |-> (!msg_valid && !log_req && cor_status_set == '0
                        && unc_status_set == '0 && devsta_set == '0));

    assert_cor_devsta_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cor_status_set != '0) |-> devsta_set[0]);

    assert_status_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cor_status_set) && $onehot0(unc_status_set));

    assert_sev_pairs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(devsta_set[1] && devsta_set[2]));

    assert_masked_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((unc_status_set != '0) && !log_req) |-> !msg_valid);

    assert_fatal_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_sev == 2'd2) |-> devsta_set[2]);

    assert_code_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_sev != 2'd3));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(evt_valid) |-> (!msg_valid && !evt_reject && !log_req));

endmodule

bind err_sig_classifier err_sig_classifier_chk #(.ERR_W(ERR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .evt_valid      (evt_valid),
    .cor_status_set (cor_status_set),
    .unc_status_set (unc_status_set),
    .devsta_set     (devsta_set),
    .log_req        (log_req),
    .msg_valid      (msg_valid),
    .msg_sev        (msg_sev),
    .evt_reject     (evt_reject)
);

// File: tb/err_sig_classifier_tb.sv
module err_sig_classifier_tb;
    localparam int          W       = 32;
    localparam logic [31:0] CSUP    = 32'h0000_F1C1;
    localparam logic [31:0] USUP    = 32'h03FF_F030;
    localparam int          URB     = 20;
    localparam int          ADVB    = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_valid = 1'b0, evt_is_cor = 1'b0, evt_maybe_adv = 1'b0;
    logic [W-1:0] evt_status = '0, cor_mask = '0, unc_mask = '0, unc_sev = '0;
    logic cor_rpt_en = 0, nonfatal_rpt_en = 0, fatal_rpt_en = 0, ur_rpt_en = 0, serr_en = 0;
    logic [W-1:0] cor_status_set, unc_status_set;
    logic [3:0]   devsta_set;
    logic         log_req, msg_valid, evt_reject;
    logic [1:0]   msg_sev;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [W-1:0] e_cor, e_unc;
    logic [3:0]   e_dev;
    logic         e_log, e_msg, e_rej;
    logic [1:0]   e_sev;

    always #2 clk = ~clk;

    err_sig_classifier u_dut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_status(evt_status),
        .evt_is_cor(evt_is_cor), .evt_maybe_adv(evt_maybe_adv), .cor_mask(cor_mask),
        .unc_mask(unc_mask), .unc_sev(unc_sev), .cor_rpt_en(cor_rpt_en),
        .nonfatal_rpt_en(nonfatal_rpt_en), .fatal_rpt_en(fatal_rpt_en),
        .ur_rpt_en(ur_rpt_en), .serr_en(serr_en), .cor_status_set(cor_status_set),
        .unc_status_set(unc_status_set), .devsta_set(devsta_set), .log_req(log_req),
        .msg_valid(msg_valid), .msg_sev(msg_sev), .evt_reject(evt_reject)
    );

    // Behavioural reference: expected outputs for the inputs now applied.
    task automatic model();
        logic [W-1:0] kept;
        bit ur, fat, adv, cmask, umask, corlike;
        e_cor = '0; e_unc = '0; e_dev = '0; e_log = 0; e_msg = 0; e_sev = 0; e_rej = 0;
        if (!rst_n || !evt_valid) return;
        kept = evt_status & (evt_is_cor ? CSUP : USUP);
        if ($countones(kept) != 1) begin e_rej = 1; return; end
        ur   = !evt_is_cor && (kept == (32'd1 << URB));
        fat  = !evt_is_cor && ((kept & unc_sev) != 0);
        adv  = !evt_is_cor && !fat && evt_maybe_adv;
        umask = (kept & unc_mask) != 0;
        corlike = evt_is_cor || adv;
        if (ur) e_dev[3] = 1;
        if (corlike) begin
            e_dev[0] = 1;
            e_cor = evt_is_cor ? kept : (32'd1 << ADVB);
            cmask = (e_cor & cor_mask) != 0;
            if (!cmask) begin
                if (adv && !umask) begin e_log = 1; e_unc = kept; end
                if (cor_rpt_en && (!ur || ur_rpt_en)) e_msg = 1;
            end
        end else begin
            if (fat) e_dev[2] = 1; else e_dev[1] = 1;
            e_unc = kept;
            if (!umask) begin
                e_log = 1;
                if (ur && !ur_rpt_en && !serr_en) e_msg = 0;
                else if (fat) e_msg = serr_en || fatal_rpt_en;
                else e_msg = serr_en || nonfatal_rpt_en;
                if (e_msg) e_sev = fat ? 2 : 1;
            end
        end
    endtask

    // Apply current inputs for one cycle, then compare at the next negedge.
    task automatic go(input string tag);
        model();
        @(negedge clk);
        n_tests++;
        if (cor_status_set !== e_cor || unc_status_set !== e_unc || devsta_set !== e_dev ||
            log_req !== e_log || msg_valid !== e_msg || msg_sev !== e_sev || evt_reject !== e_rej) begin
            n_fail++;
            $display("FAIL %s: act cor=%h unc=%h dev=%b log=%b msg=%b sev=%0d rej=%b exp cor=%h unc=%h dev=%b log=%b msg=%b sev=%0d rej=%b",
                tag, cor_status_set, unc_status_set, devsta_set, log_req, msg_valid, msg_sev, evt_reject,
                e_cor, e_unc, e_dev, e_log, e_msg, e_sev, e_rej);
        end
    endtask

    task automatic ev(input string tag, input logic [W-1:0] st, input bit cor, input bit adv);
        evt_valid = 1; evt_status = st; evt_is_cor = cor; evt_maybe_adv = adv;
        go(tag);
        evt_valid = 0; evt_status = '0;
        go({tag, " idle R12"});
    endtask

    task automatic en(input bit c, input bit nf, input bit f, input bit u, input bit s);
        cor_rpt_en = c; nonfatal_rpt_en = nf; fatal_rpt_en = f; ur_rpt_en = u; serr_en = s;
    endtask

    initial begin
        go("R12 reset"); go("R12 reset");
        evt_valid = 1; evt_status = 32'h1; evt_is_cor = 1;
        go("R12 event during reset");
        evt_valid = 0; rst_n = 1;
        go("R12 after reset");

        en(1, 0, 0, 0, 0);
        ev("R2 R4 cor bit6 enabled", 32'h40, 1, 0);
        ev("R1 zero status", 32'h0, 1, 0);
        ev("R1 multi bit", 32'h41, 1, 0);
        ev("R1 cor-unsupported bit 2", 32'h4, 1, 0);
        ev("R1 uncor-unsupported bit 0", 32'h1, 0, 0);
        cor_mask = 32'h40;
        ev("R3 cor masked", 32'h40, 1, 0);
        cor_mask = 0; en(0, 1, 1, 1, 1);
        ev("R4 cor reporting off", 32'h1000, 1, 0);

        unc_sev = 32'h0004_0010;
        en(0, 0, 0, 0, 1);
        ev("R5 R8 fatal via serr", 32'h10, 0, 0);
        en(0, 0, 1, 0, 0);
        ev("R8 fatal via fatal_en", 32'h40000, 0, 0);
        en(0, 1, 0, 0, 0);
        ev("R8 fatal no enable", 32'h10, 0, 0);
        ev("R5 R7 nonfatal logged", 32'h1000, 0, 0);
        en(0, 0, 0, 0, 0);
        ev("R8 nonfatal no enable", 32'h1000, 0, 0);
        unc_mask = 32'h1000; en(1, 1, 1, 1, 1);
        ev("R6 masked uncor", 32'h1000, 0, 0);
        unc_mask = 0;

        en(0, 1, 0, 0, 0);
        ev("R9 UR silent", 32'h0010_0000, 0, 0);
        en(0, 0, 0, 0, 1);
        ev("R9 UR via serr", 32'h0010_0000, 0, 0);
        en(0, 1, 0, 1, 0);
        ev("R9 UR via ur_en", 32'h0010_0000, 0, 0);

        en(1, 0, 0, 0, 0);
        ev("R10 advisory unmasked", 32'h4000, 0, 1);
        unc_mask = 32'h4000;
        ev("R10 advisory uncor masked", 32'h4000, 0, 1);
        unc_mask = 0; cor_mask = 32'h2000;
        ev("R11 advisory cor masked", 32'h4000, 0, 1);
        cor_mask = 0;
        ev("R10 advisory UR no ur_en", 32'h0010_0000, 0, 1);
        en(1, 0, 0, 1, 0);
        ev("R10 advisory UR with ur_en", 32'h0010_0000, 0, 1);
        en(0, 0, 1, 0, 1);
        ev("R5 fatal ignores advisory", 32'h10, 0, 1);

        for (int i = 0; i < 400; i++) begin
            int b;
            b = $urandom_range(31);
            evt_valid = ($urandom_range(3) != 0);
            evt_status = ($urandom_range(4) == 0) ? $urandom() : (32'd1 << b);
            evt_is_cor = $urandom_range(1); evt_maybe_adv = $urandom_range(1);
            cor_mask = $urandom() & $urandom(); unc_mask = $urandom() & $urandom();
            unc_sev = $urandom();
            en($urandom_range(1), $urandom_range(1), $urandom_range(1), $urandom_range(1), $urandom_range(1));
            go("R12 mixed stream");
        end
        evt_valid = 0;
        go("R12 final idle");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R12 watchdog expired: act running exp finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule